// File: doc/BRIEF.md
# Integer ALU with Carry and Compare Flag

This block is the integer execution unit of a 32-bit pipeline. Each cycle it takes two register operands, a 16-bit immediate, an operation code and a flag-write enable. From these it forms a result word in combinational logic. The operations are arithmetic, bitwise logic, shifts and upper-immediate loads. It also works out what the carry and compare-flag registers would become under that operation.

Two status bits are kept in flip-flops inside the block: a carry bit and a compare flag. Add-type operations may change the carry. Compare operations may change the flag. Neither bit changes unless the flag-write enable is high and the operation is of the matching kind. A compare produces no result word; it only yields a true or false flag.

Top module: `int_alu`

## Requirements
- R1: ADD (op 0) gives a+b and ADDI (op 2) gives a plus the sign-extended immediate. With flag_we high, the carry register takes the unsigned carry out of bit 31 at the next edge.
- R2: ADDC (op 1) gives a+b plus the current carry register, and with flag_we high it updates the carry from the carry out.
- R3: SUB (op 3) gives a-b and never changes the carry register.
- R4: The logic operations are AND (op 4), OR (op 5), XOR (op 6), ANDI (op 7), ORI (op 8) and XORI (op 9). ANDI and ORI zero-extend the immediate, while XORI sign-extends it.
- R5: LUI (op 14) gives the immediate in bits 31:16 with zeros below.
- R6: The register shifts are SLL (op 10), SRL (op 11) and SRA (op 12). Each uses only b[4:0] as the amount. SLL and SRL fill with zeros, and SRA fills with bit 31 of a.
- R7: SHI (op 13) shifts a by imm[4:0]. The shift direction comes from imm[7:6]: 01 gives a logical right shift, 10 gives an arithmetic right shift, and 00 or 11 gives a left shift.
- R8: An op with bit 5 set is a compare, and its result is 0. The condition comes from op[3:0]: 0 EQ, 1 NE, 2 GTU, 3 GEU, 4 LTU, 5 LEU, 10 GTS, 11 GES, 12 LTS, 13 LES. Any other code is false. flag_next is 1 when the condition holds and 0 when it does not, and with flag_we high it is stored at the next edge.
- R9: With op bit 4 set, a compare uses the sign-extended immediate as its second operand. This holds for the unsigned conditions too.
- R10: Reset clears carry and flag. The carry changes only on an add-type op (0, 1, 2) with flag_we high. The flag changes only on a compare with flag_we high.
- R11: carry_next equals carry on any op other than 0, 1 and 2, and flag_next equals flag on any non-compare op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 6 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| imm | input | 16 | Immediate field |
| flag_we | input | 1 | Allows carry/flag update this cycle |
| result | output | 32 | Combinational result word |
| carry_next | output | 1 | Carry value this op would store |
| flag_next | output | 1 | Flag value this op would store |
| carry | output | 1 | Registered carry |
| flag | output | 1 | Registered compare flag |

## Verification
The only internal state is the carry and flag pair, and both are visible at the ports. A wrong update shows on carry or flag one edge after the operation. A stale carry also corrupts the very next ADDC result word in the same cycle it is issued. A missing hold shows as a status bit that changes after a disabled or unrelated op. So every scored operation compares both registers after its edge, as well as the combinational outputs before it.

// File: rtl/int_alu.sv
`timescale 1ns/1ps
module int_alu #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    op_sel,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [IW-1:0] imm,
  input  logic          flag_we,
  output logic [W-1:0]  result,
  output logic          carry_next,
  output logic          flag_next,
  output logic          carry,
  output logic          flag
);
  localparam int SW = $clog2(W);
  localparam logic [5:0] OP_ADD = 6'd0, OP_ADDC = 6'd1, OP_ADDI = 6'd2, OP_SUB = 6'd3,
                         OP_AND = 6'd4, OP_OR = 6'd5, OP_XOR = 6'd6, OP_ANDI = 6'd7,
                         OP_ORI = 6'd8, OP_XORI = 6'd9, OP_SLL = 6'd10, OP_SRL = 6'd11,
                         OP_SRA = 6'd12, OP_SHI = 6'd13, OP_LUI = 6'd14;

  wire [W-1:0] imm_sx = {{(W-IW){imm[IW-1]}}, imm};
  wire [W-1:0] imm_zx = {{(W-IW){1'b0}}, imm};
  wire         is_cmp = op_sel[5];
  wire         is_add = (op_sel == OP_ADD) || (op_sel == OP_ADDC) || (op_sel == OP_ADDI);

  logic [W:0]   sum;
  logic [W-1:0] alu_res;

  always_comb begin
    sum     = '0;
    alu_res = '0;
    unique case (op_sel)
      OP_ADD:  sum = {1'b0, opnd_a} + {1'b0, opnd_b};
      OP_ADDC: sum = {1'b0, opnd_a} + {1'b0, opnd_b} + {{W{1'b0}}, carry};
      OP_ADDI: sum = {1'b0, opnd_a} + {1'b0, imm_sx};
      OP_SUB:  alu_res = opnd_a - opnd_b;
      OP_AND:  alu_res = opnd_a & opnd_b;
      OP_OR:   alu_res = opnd_a | opnd_b;
      OP_XOR:  alu_res = opnd_a ^ opnd_b;
      OP_ANDI: alu_res = opnd_a & imm_zx;
      OP_ORI:  alu_res = opnd_a | imm_zx;
      OP_XORI: alu_res = opnd_a ^ imm_sx;
      OP_SLL:  alu_res = opnd_a << opnd_b[SW-1:0];
      OP_SRL:  alu_res = opnd_a >> opnd_b[SW-1:0];
      OP_SRA:  alu_res = W'($signed(opnd_a) >>> opnd_b[SW-1:0]);
      OP_SHI: begin
        case (imm[7:6])
          2'b01:   alu_res = opnd_a >> imm[SW-1:0];
          2'b10:   alu_res = W'($signed(opnd_a) >>> imm[SW-1:0]);
          default: alu_res = opnd_a << imm[SW-1:0];
        endcase
      end
      OP_LUI:  alu_res = {imm, {(W-IW){1'b0}}};
      default: alu_res = '0;
    endcase
  end

  assign result = is_add ? sum[W-1:0] : alu_res;

  wire [W-1:0] cmp_b = op_sel[4] ? imm_sx : opnd_b;
  wire eq  = (opnd_a == cmp_b);
  wire ltu = (opnd_a < cmp_b);
  wire lts = ($signed(opnd_a) < $signed(cmp_b));
  logic cond;

  always_comb begin
    case (op_sel[3:0])
      4'd0:    cond = eq;
      4'd1:    cond = !eq;
      4'd2:    cond = !ltu && !eq;
      4'd3:    cond = !ltu;
      4'd4:    cond = ltu;
      4'd5:    cond = ltu || eq;
      4'd10:   cond = !lts && !eq;
      4'd11:   cond = !lts;
      4'd12:   cond = lts;
      4'd13:   cond = lts || eq;
      default: cond = 1'b0;
    endcase
  end

  assign carry_next = is_add ? sum[W] : carry;
  assign flag_next  = is_cmp ? cond : flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (flag_we && is_add) carry <= carry_next;
      if (flag_we && is_cmp) flag  <= flag_next;
    end
  end
endmodule

// File: rtl/int_alu_chk.sv
`timescale 1ns/1ps
module int_alu_chk #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [5:0]    op_sel,
  input logic [W-1:0]  opnd_a,
  input logic [W-1:0]  opnd_b,
  input logic [IW-1:0] imm,
  input logic          flag_we,
  input logic [W-1:0]  result,
  input logic          carry_next,
  input logic          flag_next,
  input logic          carry,
  input logic          flag
);
  localparam int SW = $clog2(W);
  wire [W:0] plain_sum = {1'b0, opnd_a} + {1'b0, opnd_b};
  wire add_kind = (op_sel == 6'd0) || (op_sel == 6'd1) || (op_sel == 6'd2);

  a_r1_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_sel == 6'd0) |=> carry == $past(plain_sum[W]));
  a_r3_sub_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 6'd3) |=> $stable(carry));
  a_r5_lui_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 6'd14) |-> result == {imm, {(W-IW){1'b0}}});
  a_r6_sll_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 6'd10) |-> result == (opnd_a << opnd_b[SW-1:0]));
  a_r8_cmp_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel[5] |-> result == '0);
  a_r10_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_we && add_kind) |=> $stable(carry));
  a_r10_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_we && op_sel[5]) |=> $stable(flag));
  a_r11_flag_next_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_sel[5] |-> flag_next == flag);
  a_r11_carry_next_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !add_kind |-> carry_next == carry);
endmodule

bind int_alu int_alu_chk #(.W(W), .IW(IW)) chk_i (.*);

// File: tb/int_alu_tb_top.sv
`timescale 1ns/1ps
module int_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  op_sel = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [15:0] imm = '0;
  logic        flag_we = 1'b0;
  logic [31:0] result;
  logic        carry_next, flag_next, carry, flag;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit m_c = 0, m_f = 0;

  typedef struct {
    logic [31:0] res;
    logic cn, fn, c_after, f_after;
    string tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  int_alu dut_i (.clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
                 .imm(imm), .flag_we(flag_we), .result(result), .carry_next(carry_next),
                 .flag_next(flag_next), .carry(carry), .flag(flag));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void model(input logic [5:0] op, input logic [31:0] a, b,
                                input logic [15:0] im, input bit c, f,
                                output logic [31:0] r, output bit cn, fn);
    logic [63:0] s;
    logic [31:0] sx, sb;
    bit cond;
    sx = {{16{im[15]}}, im};
    r = 0; cn = c; fn = f;
    if (op[5]) begin
      sb = op[4] ? sx : b;
      case (op[3:0])
        0: cond = a == sb;
        1: cond = a != sb;
        2: cond = a > sb;
        3: cond = a >= sb;
        4: cond = a < sb;
        5: cond = a <= sb;
        10: cond = $signed(a) > $signed(sb);
        11: cond = $signed(a) >= $signed(sb);
        12: cond = $signed(a) < $signed(sb);
        13: cond = $signed(a) <= $signed(sb);
        default: cond = 0;
      endcase
      fn = cond;
    end else begin
      case (op)
        0: begin s = 64'(a) + 64'(b); r = s[31:0]; cn = s[32]; end
        1: begin s = 64'(a) + 64'(b) + 64'(c); r = s[31:0]; cn = s[32]; end
        2: begin s = 64'(a) + 64'(sx); r = s[31:0]; cn = s[32]; end
        3: r = a - b;
        4: r = a & b;
        5: r = a | b;
        6: r = a ^ b;
        7: r = a & {16'h0, im};
        8: r = a | {16'h0, im};
        9: r = a ^ sx;
        10: r = a << b[4:0];
        11: r = a >> b[4:0];
        12: r = $signed(a) >>> b[4:0];
        13: r = (im[7:6] == 2'b01) ? a >> im[4:0] :
                (im[7:6] == 2'b10) ? 32'($signed(a) >>> im[4:0]) : a << im[4:0];
        14: r = {im, 16'h0};
        default: r = 0;
      endcase
    end
  endfunction

  task automatic go(input logic [5:0] op, input logic [31:0] a, b, input logic [15:0] im,
                    input bit we, input string tag);
    item_t it;
    logic [31:0] r;
    bit cn, fn;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; imm = im; flag_we = we;
    model(op, a, b, im, m_c, m_f, r, cn, fn);
    it.res = r; it.cn = cn; it.fn = fn; it.tag = tag;
    if (we && !op[5] && op <= 2) m_c = cn;
    if (we && op[5]) m_f = fn;
    it.c_after = m_c; it.f_after = m_f;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk); #1;
      if (q.size() != 0) begin
        it = q.pop_front();
        chk(result == it.res, it.tag, "result", result, it.res);
        chk(carry_next == it.cn, it.tag, "carry_next (R11)", 32'(carry_next), 32'(it.cn));
        chk(flag_next == it.fn, it.tag, "flag_next (R11)", 32'(flag_next), 32'(it.fn));
        @(posedge clk); #1;
        chk(carry == it.c_after, it.tag, "carry reg (R10)", 32'(carry), 32'(it.c_after));
        chk(flag == it.f_after, it.tag, "flag reg (R10)", 32'(flag), 32'(it.f_after));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    op_sel = 6'd0; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h1; flag_we = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(carry == 0 && flag == 0, "R10", "reset clears carry/flag", {carry, flag}, 0);
    flag_we = 0; op_sel = 6'd4;
    rst_n = 1'b1;
    go(0, 32'hFFFF_FFFF, 32'h1, 0, 1, "R1 add carry out");
    go(1, 32'd5, 32'd6, 0, 1, "R2 addc with carry in");
    go(1, 32'd5, 32'd6, 0, 1, "R2 addc without carry");
    go(2, 32'd10, 0, 16'hFFFF, 1, "R1 addi sign-extended");
    go(3, 32'd3, 32'd5, 0, 1, "R3 sub keeps carry");
    go(0, 32'd1, 32'd1, 0, 0, "R10 add without write enable");
    go(0, 32'h8000_0000, 32'h8000_0000, 0, 1, "R1 add msb carry");
    go(4, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 0, "R4 and");
    go(5, 32'hF000_0001, 32'h0000_1230, 0, 0, "R4 or");
    go(6, 32'hAAAA_5555, 32'hFFFF_0000, 0, 0, "R4 xor");
    go(7, 32'hFFFF_FFFF, 0, 16'h8001, 0, "R4 andi zero-extend");
    go(8, 32'h1200_0000, 0, 16'h8001, 0, "R4 ori zero-extend");
    go(9, 32'h0000_00FF, 0, 16'hFFF0, 0, "R4 xori sign-extend");
    go(14, 32'hDEAD_BEEF, 0, 16'hABCD, 0, "R5 lui");
    go(10, 32'h0000_0013, 32'hFFFF_FF23, 0, 0, "R6 sll low 5 bits");
    go(11, 32'h8000_0000, 32'h0000_0024, 0, 0, "R6 srl zero fill");
    go(12, 32'h8000_0000, 32'h0000_0024, 0, 0, "R6 sra sign fill");
    go(13, 32'h8000_00F0, 0, 16'h0004, 0, "R7 shi left");
    go(13, 32'h8000_00F0, 0, 16'h0044, 0, "R7 shi logical right");
    go(13, 32'h8000_00F0, 0, 16'h0084, 0, "R7 shi arith right");
    go(13, 32'h8000_00F0, 0, 16'h00C1, 0, "R7 shi code 11 left");
    go(6'h20, 32'd7, 32'd7, 0, 1, "R8 eq true");
    go(6'h21, 32'd7, 32'd7, 0, 1, "R8 ne false");
    go(6'h22, 32'hFFFF_FFFF, 32'd1, 0, 1, "R8 gtu");
    go(6'h2A, 32'hFFFF_FFFF, 32'd1, 0, 1, "R8 gts");
    go(6'h2B, 32'd1, 32'd1, 0, 1, "R8 ges equal");
    go(6'h2C, 32'h8000_0000, 32'd0, 0, 1, "R8 lts");
    go(6'h25, 32'h8000_0000, 32'd0, 0, 1, "R8 leu");
    go(6'h23, 32'd4, 32'd4, 0, 1, "R8 geu equal");
    go(6'h2D, 32'd4, 32'd4, 0, 1, "R8 les equal");
    go(6'h26, 32'd4, 32'd4, 0, 1, "R8 unused cond false");
    go(6'h34, 32'd5, 0, 16'hFFFF, 1, "R9 ltui sign-extended");
    go(6'h3B, 32'hFFFF_FFFE, 0, 16'hFFFE, 1, "R9 gesi");
    go(6'h32, 32'd5, 0, 16'hFFFF, 1, "R9 gtui false");
    go(6'h20, 32'd1, 32'd1, 0, 0, "R10 compare without write enable");
    go(0, 32'd1, 32'd2, 0, 1, "R10 add leaves flag");
    go(6'h24, 32'd1, 32'd2, 0, 1, "R10 compare leaves carry");
    @(negedge clk); flag_we = 0; op_sel = 6'd4;
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule